// File: doc/BRIEF.md
# Synchronous Multi-Converter Sampling Sequencer

This block paces the acquisition side of a multi-feeder protection front end. A programmable interval timer produces one tick per sample period (at 50 Hz, twelve samples per power cycle). On each tick the block starts all analog converters in the same clock cycle. It then waits for every converter to report completion, without polling. After that it reads the twelve conversion results over a narrow parallel bus, one channel per clock and in a fixed order.

The twelve channels carry two phase currents for each of six feeders. As each feeder's second phase is read, the block forms the phase-difference current d = A − B. It compares this value with the value stored one power cycle (twelve accepted samples) earlier. If the change exceeds a programmable threshold, the block raises a one-cycle fault-start strobe for that feeder. Each feeder's strobe can be enabled on its own. If the converters do not all finish within a timeout window, the period is dropped and a sticky error flag is raised.

Top module: `sampling_sequencer`

## Requirements
- R1: A start is issued once every `periodLen` clock cycles, counted by a free-running timer that begins at reset.
- R2: Every start drives all converter start bits high together, in the same cycle and for exactly one cycle.
- R3: Readout begins only after each converter has pulsed its done input at least once since the latest start. The done pulses may arrive in any order and in different cycles.
- R4: A readout holds `rdEn` high for twelve consecutive cycles with `rdSel` counting 0 to 11. Channel c belongs to converter c/4, input c%4. Feeder L takes phase A from channel 2L and phase B from channel 2L+1.
- R5: One cycle after phase B of feeder L is read, `lineValid[L]` pulses for one cycle. In that same cycle, `lineDiff` bits [13L+12:13L] hold A − B as a 13-bit two's-complement value.
- R6: `faultStart[L]` pulses together with `lineValid[L]` when all three conditions hold: |d − d(twelve accepted samples earlier)| is strictly greater than `threshold`; `lineEnable[L]` is 1; and the history is full.
- R7: No fault-start strobe is raised until twelve complete readouts have been accepted since reset.
- R8: With `lineEnable[L]` at 0, feeder L raises no fault-start strobe, and its `lineValid` and `lineDiff` behave exactly as when enabled.
- R9: If not all done pulses arrive within `TIMEOUT_CYC` cycles of a start, `timeoutErr` rises and stays high until reset. That period produces no read and no `lineValid`, and it does not advance the one-cycle history.
- R10: While reset is held, `convStart`, `rdEn`, `lineValid`, `faultStart` and `timeoutErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| periodLen | input | PERIOD_W | Sample period in clock cycles |
| threshold | input | DATA_W+2 | Abrupt-change limit on the magnitude of the difference change |
| lineEnable | input | NUM_LINES | Per-feeder fault-start enable |
| convStart | output | NUM_CONV | Converter start pulses |
| convDone | input | NUM_CONV | Converter completion pulses |
| rdEn | output | 1 | Read bus strobe |
| rdSel | output | SEL_W | Channel select on the read bus |
| rdData | input | DATA_W | Selected conversion result, two's complement, valid while rdEn is high |
| lineDiff | output | NUM_LINES*(DATA_W+1) | Per-feeder phase-difference current |
| lineValid | output | NUM_LINES | Per-feeder result-valid pulse |
| faultStart | output | NUM_LINES | Per-feeder fault-start pulse |
| timeoutErr | output | 1 | Sticky conversion-timeout flag |

## Verification
The assertions assume a well-behaved environment. Each converter pulses done only after a start and at most once per sequence. `rdData` answers `rdSel` in the same cycle. `periodLen` exceeds the timeout plus the twelve-cycle readout, so a tick never lands while a sequence is in flight. The stimulus keeps within these limits: it holds the period at 48 cycles with a 16-cycle timeout, and it answers each start after 3, 5 or 7 cycles. The timeout is exercised only by withholding one converter's done pulse for a whole period. Thresholds, enables and channel values change only between readouts.

// File: rtl/samp_seq_pkg.sv
package samp_seq_pkg;
  // Widest feeder index carried in the control strobes.
  parameter int unsigned MAX_LINE_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ
  } seqState_t;

  // Strobes from control to datapath, valid in the read cycle.
  typedef struct packed {
    logic                  capA;     // phase A on rdData
    logic                  capB;     // phase B on rdData
    logic [MAX_LINE_W-1:0] line;     // feeder being read
    logic                  advance;  // last channel of the period
  } seqStrobe_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import samp_seq_pkg::*;
#(
  parameter int NUM_CONV    = 3,
  parameter int NUM_CH      = 12,
  parameter int PERIOD_W    = 20,
  parameter int TIMEOUT_CYC = 10000,
  localparam int SEL_W      = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PERIOD_W-1:0] periodLen,
  input  logic [NUM_CONV-1:0] convDone,
  output logic [NUM_CONV-1:0] convStart,
  output logic                rdEn,
  output logic [SEL_W-1:0]    rdSel,
  output logic                timeoutErr,
  output seqStrobe_t          strobe
);
  localparam int TO_W = $clog2(TIMEOUT_CYC + 1);

  seqState_t           state;
  logic [PERIOD_W-1:0] tmr;
  logic                tick;
  logic [NUM_CONV-1:0] doneSeen;
  logic [NUM_CONV-1:0] doneNext;
  logic [TO_W-1:0]     toCnt;

  assign tick     = (tmr >= PERIOD_W'(periodLen - 1'b1));
  assign doneNext = doneSeen | convDone;

  always_ff @(posedge clk) begin
    if (!rstN) tmr <= '0;
    else if (tick) tmr <= '0;
    else tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      convStart  <= '0;
      doneSeen   <= '0;
      toCnt      <= '0;
      rdSel      <= '0;
      timeoutErr <= 1'b0;
    end else begin
      convStart <= '0;
      case (state)
        ST_IDLE: if (tick) begin
          convStart <= '1;
          doneSeen  <= '0;
          toCnt     <= '0;
          state     <= ST_WAIT;
        end
        ST_WAIT: begin
          doneSeen <= doneNext;
          if (&doneNext) begin
            rdSel <= '0;
            state <= ST_READ;
          end else if (toCnt == TO_W'(TIMEOUT_CYC - 1)) begin
            timeoutErr <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            toCnt <= toCnt + 1'b1;
          end
        end
        ST_READ: begin
          rdSel <= rdSel + 1'b1;
          if (rdSel == SEL_W'(NUM_CH - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rdEn = (state == ST_READ);

  always_comb begin
    strobe.capA    = rdEn && !rdSel[0];
    strobe.capB    = rdEn && rdSel[0];
    strobe.line    = MAX_LINE_W'(rdSel >> 1);
    strobe.advance = rdEn && (rdSel == SEL_W'(NUM_CH - 1));
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import samp_seq_pkg::*;
#(
  parameter int NUM_LINES = 6,
  parameter int DATA_W    = 12,
  parameter int HIST      = 12,
  localparam int DIFF_W   = DATA_W + 1,
  localparam int DELTA_W  = DATA_W + 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seqStrobe_t                  strobe,
  input  logic [DATA_W-1:0]           rdData,
  input  logic [DELTA_W-1:0]          threshold,
  input  logic [NUM_LINES-1:0]        lineEnable,
  output logic [NUM_LINES*DIFF_W-1:0] lineDiff,
  output logic [NUM_LINES-1:0]        lineValid,
  output logic [NUM_LINES-1:0]        faultStart
);
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int PTR_W  = $clog2(HIST);
  localparam int FILL_W = $clog2(HIST + 1);

  logic signed [DIFF_W-1:0] ring [NUM_LINES][HIST];
  logic signed [DIFF_W-1:0] diffReg [NUM_LINES];
  logic signed [DATA_W-1:0] phaseA;
  logic signed [DATA_W-1:0] sampleS;
  logic signed [DIFF_W-1:0] diffNow;
  logic signed [DIFF_W-1:0] diffOld;
  logic signed [DELTA_W-1:0] delta;
  logic [DELTA_W-1:0]       mag;
  logic [LINE_W-1:0]        lineIdx;
  logic [PTR_W-1:0]         ptr;
  logic [FILL_W-1:0]        fill;
  logic                     histFull;

  assign sampleS  = signed'(rdData);
  assign lineIdx  = strobe.line[LINE_W-1:0];
  assign diffNow  = DIFF_W'(phaseA) - DIFF_W'(sampleS);
  assign diffOld  = ring[lineIdx][ptr];
  assign delta    = DELTA_W'(diffNow) - DELTA_W'(diffOld);
  assign mag      = delta[DELTA_W-1] ? DELTA_W'(-delta) : DELTA_W'(delta);
  assign histFull = (fill == FILL_W'(HIST));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseA     <= '0;
      ptr        <= '0;
      fill       <= '0;
      lineValid  <= '0;
      faultStart <= '0;
      for (int l = 0; l < NUM_LINES; l++) begin
        diffReg[l] <= '0;
        for (int h = 0; h < HIST; h++) ring[l][h] <= '0;
      end
    end else begin
      lineValid  <= '0;
      faultStart <= '0;
      if (strobe.capA) phaseA <= sampleS;
      if (strobe.capB) begin
        ring[lineIdx][ptr]  <= diffNow;
        diffReg[lineIdx]    <= diffNow;
        lineValid[lineIdx]  <= 1'b1;
        faultStart[lineIdx] <= histFull && lineEnable[lineIdx] && (mag > threshold);
      end
      if (strobe.advance) begin
        ptr <= (ptr == PTR_W'(HIST - 1)) ? '0 : ptr + 1'b1;
        if (!histFull) fill <= fill + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_out
    assign lineDiff[g*DIFF_W +: DIFF_W] = diffReg[g];
  end
endmodule

// File: rtl/sampling_sequencer.sv
module sampling_sequencer
  import samp_seq_pkg::*;
#(
  parameter int NUM_CONV    = 3,
  parameter int CH_PER_CONV = 4,
  parameter int DATA_W      = 12,
  parameter int HIST        = 12,
  parameter int PERIOD_W    = 20,
  parameter int TIMEOUT_CYC = 10000,
  localparam int NUM_CH     = NUM_CONV * CH_PER_CONV,
  localparam int NUM_LINES  = NUM_CH / 2,
  localparam int SEL_W      = $clog2(NUM_CH)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [PERIOD_W-1:0]               periodLen,
  input  logic [DATA_W+1:0]                 threshold,
  input  logic [NUM_LINES-1:0]              lineEnable,
  output logic [NUM_CONV-1:0]               convStart,
  input  logic [NUM_CONV-1:0]               convDone,
  output logic                              rdEn,
  output logic [SEL_W-1:0]                  rdSel,
  input  logic [DATA_W-1:0]                 rdData,
  output logic [NUM_LINES*(DATA_W+1)-1:0]   lineDiff,
  output logic [NUM_LINES-1:0]              lineValid,
  output logic [NUM_LINES-1:0]              faultStart,
  output logic                              timeoutErr
);
  seqStrobe_t strobe;

  seq_ctrl #(
    .NUM_CONV(NUM_CONV), .NUM_CH(NUM_CH),
    .PERIOD_W(PERIOD_W), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .periodLen(periodLen), .convDone(convDone),
    .convStart(convStart), .rdEn(rdEn), .rdSel(rdSel),
    .timeoutErr(timeoutErr), .strobe(strobe)
  );

  seq_datapath #(
    .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .HIST(HIST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(rdData),
    .threshold(threshold), .lineEnable(lineEnable), .lineDiff(lineDiff),
    .lineValid(lineValid), .faultStart(faultStart)
  );
endmodule

// File: rtl/sampling_sequencer_chk.sv
module sampling_sequencer_chk #(
  parameter int NUM_CONV  = 3,
  parameter int NUM_CH    = 12,
  parameter int NUM_LINES = 6,
  localparam int SEL_W    = $clog2(NUM_CH)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_CONV-1:0]  convStart,
  input logic                 rdEn,
  input logic [SEL_W-1:0]     rdSel,
  input logic [NUM_LINES-1:0] lineValid,
  input logic [NUM_LINES-1:0] faultStart,
  input logic                 timeoutErr
);
  a_r2_start_together: assert property (@(posedge clk) disable iff (!rstN)
    (|convStart) |-> (&convStart));

  a_r2_start_single: assert property (@(posedge clk) disable iff (!rstN)
    (|convStart) |=> (convStart == '0));

  a_r3_no_read_at_start: assert property (@(posedge clk) disable iff (!rstN)
    (|convStart) |-> !rdEn);

  a_r4_read_begins_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdEn) |-> (rdSel == '0));

  a_r4_sel_steps: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSel != SEL_W'(NUM_CH - 1)) |=> (rdEn && rdSel == SEL_W'($past(rdSel) + 1'b1)));

  a_r5_valid_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lineValid));

  a_r5_valid_after_b: assert property (@(posedge clk) disable iff (!rstN)
    (|lineValid) |-> ($past(rdEn) && $past(rdSel[0])));

  a_r6_fault_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    ((faultStart & ~lineValid) == '0));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> timeoutErr);
endmodule

bind sampling_sequencer sampling_sequencer_chk #(
  .NUM_CONV(NUM_CONV), .NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES)
) u_chk (
  .clk(clk), .rstN(rstN), .convStart(convStart), .rdEn(rdEn), .rdSel(rdSel),
  .lineValid(lineValid), .faultStart(faultStart), .timeoutErr(timeoutErr)
);

// File: tb/sampling_sequencer_bench.sv
`timescale 1ns/1ps
module sampling_sequencer_bench;
  localparam int PER = 48;
  localparam int NL  = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] periodLen = 20'(PER);
  logic [13:0] threshold = 14'd200;
  logic [5:0]  lineEnable = 6'h3f;
  logic [2:0]  convStart;
  logic [2:0]  convDone = '0;
  logic        rdEn;
  logic [3:0]  rdSel;
  logic [11:0] rdData;
  logic [77:0] lineDiff;
  logic [5:0]  lineValid;
  logic [5:0]  faultStart;
  logic        timeoutErr;

  always #2 clk = ~clk;

  sampling_sequencer #(.TIMEOUT_CYC(16)) u_sampling_sequencer (
    .clk(clk), .rstN(rstN), .periodLen(periodLen), .threshold(threshold),
    .lineEnable(lineEnable), .convStart(convStart), .convDone(convDone),
    .rdEn(rdEn), .rdSel(rdSel), .rdData(rdData), .lineDiff(lineDiff),
    .lineValid(lineValid), .faultStart(faultStart), .timeoutErr(timeoutErr)
  );

  int chan [12];
  int checks = 0, bad = 0;
  bit finished = 0;

  assign rdData = (rdSel < 4'd12) ? 12'(chan[rdSel]) : 12'd0;

  // Converter model: done pulse a fixed delay after start, optionally withheld.
  int  dly [3] = '{3, 7, 5};
  int  cnt [3] = '{0, 0, 0};
  bit  hold [3] = '{0, 0, 0};
  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (convStart[i]) cnt[i] <= dly[i];
      else if (cnt[i] != 0) cnt[i] <= cnt[i] - 1;
      convDone[i] <= (cnt[i] == 1) && !hold[i];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Reference model and per-period counters
  int hist [NL][12];
  int bptr = 0, bfill = 0;
  int cyc = 0, lastStart = -1, expSel = 0, rdCnt = 0;
  int validCnt [NL];
  int faultCnt [NL];
  bit [2:0] doneSeen = '0;
  bit prevStart = 0, prevRd = 0;
  logic [3:0] prevSel = '0;

  always @(negedge clk) begin
    if (!rstN) begin
      chk(convStart == 0 && !rdEn && lineValid == 0 && faultStart == 0 && !timeoutErr,
          "R10 reset outputs", int'({convStart, rdEn, lineValid, faultStart, timeoutErr}), 0);
    end else begin
      cyc++;
      if (prevStart) chk(convStart == 0, "R2 start one cycle", int'(convStart), 0);
      if (|convStart) begin
        chk(convStart == 3'b111, "R2 starts together", int'(convStart), 7);
        if (lastStart >= 0) chk(cyc - lastStart == PER, "R1 period", cyc - lastStart, PER);
        lastStart = cyc;
        doneSeen  = '0;
        expSel    = 0;
        rdCnt     = 0;
        for (int l = 0; l < NL; l++) begin validCnt[l] = 0; faultCnt[l] = 0; end
      end
      doneSeen |= convDone;
      if (rdEn) begin
        chk(doneSeen == 3'b111, "R3 read after all done", int'(doneSeen), 7);
        chk(rdSel == 4'(expSel), "R4 read order", int'(rdSel), expSel);
        expSel++;
        rdCnt++;
      end
      begin
        logic [5:0] expV;
        expV = (prevRd && prevSel[0]) ? 6'(1 << (prevSel >> 1)) : 6'd0;
        if (expV != 0 || lineValid != 0)
          chk(lineValid == expV, "R5 valid timing", int'(lineValid), int'(expV));
      end
      for (int l = 0; l < NL; l++) begin
        if (lineValid[l]) begin
          int expD, act, dd;
          bit expF;
          expD = chan[2*l] - chan[2*l+1];
          act  = int'($signed(lineDiff[l*13 +: 13]));
          chk(act == expD, "R5 line difference", act, expD);
          dd   = expD - hist[l][bptr];
          if (dd < 0) dd = -dd;
          expF = (bfill >= 12) && lineEnable[l] && (dd > int'(threshold));
          chk(faultStart[l] == expF, "R6 fault strobe", int'(faultStart[l]), int'(expF));
          hist[l][bptr] = expD;
          validCnt[l]++;
          if (faultStart[l]) faultCnt[l]++;
          if (l == NL - 1) begin
            bptr = (bptr + 1) % 12;
            if (bfill < 12) bfill++;
          end
        end
      end
      prevStart = |convStart;
      prevRd    = rdEn;
      prevSel   = rdSel;
    end
  end

  task automatic setBase();
    for (int l = 0; l < NL; l++) begin
      chan[2*l]   = 100 * (l + 1);
      chan[2*l+1] = -50 * (l + 1);
    end
  endtask

  task automatic onePeriod();
    @(negedge clk);
    while (convStart == 0) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    rstN = 1'b1;
  endtask

  // R7: twelve periods with wildly alternating feeder 0, no strobes expected
  task automatic t_prime();
    int faults = 0;
    for (int p = 0; p < 12; p++) begin
      setBase();
      chan[0] = (p % 2 == 0) ? 2000 : -2000;
      chan[1] = (p % 2 == 0) ? -2000 : 2000;
      onePeriod();
      for (int l = 0; l < NL; l++) faults += faultCnt[l];
      chk(validCnt[0] == 1, "R5 valid per period", validCnt[0], 1);
    end
    chk(faults == 0, "R7 no strobe before history full", faults, 0);
    for (int p = 0; p < 12; p++) begin setBase(); onePeriod(); end
    chk(rdCnt == 12, "R4 twelve reads", rdCnt, 12);
  endtask

  task automatic t_step();
    setBase();
    chan[4] = chan[4] + 500;
    onePeriod();
    chk(faultCnt[2] == 1, "R6 step fault line 2", faultCnt[2], 1);
    chk(faultCnt[0] == 0, "R6 quiet line 0", faultCnt[0], 0);
  endtask

  task automatic t_threshold();
    setBase(); chan[4] = chan[4] + 500;
    chan[2] = chan[2] + 200;
    onePeriod();
    chk(faultCnt[1] == 0, "R6 change equal to limit", faultCnt[1], 0);
    chan[8]  = chan[8] + 201;
    chan[11] = chan[11] + 300;
    onePeriod();
    chk(faultCnt[4] == 1, "R6 change just over limit", faultCnt[4], 1);
    chk(faultCnt[5] == 1, "R6 negative change", faultCnt[5], 1);
  endtask

  task automatic t_enable();
    lineEnable = 6'b110111;
    chan[6] = chan[6] + 600;
    onePeriod();
    chk(faultCnt[3] == 0, "R8 disabled line no strobe", faultCnt[3], 0);
    chk(validCnt[3] == 1, "R8 disabled line still valid", validCnt[3], 1);
    lineEnable = 6'h3f;
  endtask

  task automatic t_timeout();
    int vsum = 0;
    chk(timeoutErr == 0, "R9 no error yet", int'(timeoutErr), 0);
    hold[2] = 1;
    onePeriod();
    for (int l = 0; l < NL; l++) vsum += validCnt[l];
    chk(timeoutErr == 1, "R9 error raised", int'(timeoutErr), 1);
    chk(rdCnt == 0, "R9 no read", rdCnt, 0);
    chk(vsum == 0, "R9 no valid", vsum, 0);
    hold[2] = 0;
    onePeriod();
    chk(validCnt[1] == 1, "R9 recovers next period", validCnt[1], 1);
    chk(timeoutErr == 1, "R9 error sticky", int'(timeoutErr), 1);
  endtask

  initial begin
    for (int l = 0; l < NL; l++) begin
      validCnt[l] = 0; faultCnt[l] = 0;
      for (int h = 0; h < 12; h++) hist[l][h] = 0;
    end
    setBase();
    t_reset();
    t_prime();
    t_step();
    t_threshold();
    t_enable();
    t_timeout();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule